// File: doc/BRIEF.md
# Watchdog Timeout Supervisor

This block supervises a host by watching a kick input. The host must produce a valid kick edge within a set timeout window. If it does not, the block pulls its active-low alarm output low so that the host can be restarted. A hold input suspends supervision: while it is high, all timing stays at zero. Counting starts again from zero once hold returns low. A synchronous reset stands in for power-up. After reset the alarm is high and the window starts at once, with no kick needed.

Two behaviours are chosen at build time. In symmetric mode only rising kick edges count, and the alarm stays low for one timeout window. A rising kick that arrives while the alarm is low ends the alarm early, but never before a minimum low width has passed. In fixed-pulse mode both kick edges count. The alarm stays low for a separate active period and ignores all kicks while it is low.

Both inputs pass through a two-flop synchroniser and then a stability filter. The filter accepts a new level only after it has held steady for a set number of cycles, which rejects short glitches. All durations are parameters counted in clock cycles.

Top module: `wdog_supervisor`

## Requirements
- R1: With no accepted kick and hold low, the alarm goes low exactly TIMEOUT_CYC cycles after the last clearing event. The alarm stays high on every cycle before that.
- R2: In symmetric mode a rising kick clears the window and a falling kick has no effect. In fixed-pulse mode rising and falling kicks both clear it.
- R3: In symmetric mode, with no kick, the alarm stays low for TIMEOUT_CYC cycles, returns high, and asserts again one window later. The cycle repeats.
- R4: In fixed-pulse mode the alarm stays low for ACTIVE_CYC cycles. Kicks that arrive while it is low are ignored.
- R5: In symmetric mode an accepted rising kick while the alarm is low releases it. The release comes at once if MIN_LOW_CYC low cycles have passed, otherwise at the moment the low pulse reaches MIN_LOW_CYC cycles.
- R6: Every change of the alarm level restarts the window counter from zero, so the next timeout is counted from the release.
- R7: While the filtered hold level is high, the alarm cannot fall and the window stays at zero. After hold drops, the timeout is counted from zero.
- R8: If hold rises while the alarm is low, the alarm is released once the pulse has lasted at least MIN_LOW_CYC cycles. This applies in both modes.
- R9: An input level is accepted only after it has been steady for FILT_CYC consecutive cycles after the synchroniser. A pulse one cycle shorter is rejected. An accepted input change affects the window on the clock edge FILT_CYC+3 cycles after it was applied.
- R10: During reset and right after it, the alarm is high. Counting begins without any kick transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_i | input | 1 | Asynchronous kick from the supervised host |
| hold_i | input | 1 | Asynchronous hold; high suspends all supervision |
| alarm_n_o | output | 1 | Active-low timeout alarm |

## Verification
The bound checker enforces several properties on every cycle:
- The alarm never stays high longer than the window allows since the last clearing event.
- No low pulse is shorter than the minimum width.
- No low pulse is longer than the mode's low length.
- A low pulse that no early release can explain lasts exactly the full low length.
- A filtered hold keeps a high alarm high.

Only the bench scenarios can show the exact cycles of each transition. They also show that symmetric mode ignores falling kicks while fixed-pulse mode acts on them. Finally they show that glitches one cycle short of the filter length leave the timing untouched, while a pulse of the full length moves the timeout.

// File: rtl/wd_pkg.sv
package wd_pkg;

    typedef enum logic {
        MODE_SYM   = 1'b0,
        MODE_FIXED = 1'b1
    } wd_mode_e;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_ALARM = 1'b1
    } wd_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } wd_edge_t;

    function automatic int wd_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // bits needed to hold the values 0 .. n-1
    function automatic int wd_cw(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wd_sync_filter.sv
module wd_sync_filter
    import wd_pkg::*;
#(
    parameter int FILT_CYC = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output wd_edge_t dout
);
    localparam int CW = wd_cw(FILT_CYC);

    logic          s1, s2;
    logic [CW-1:0] run;
    wd_edge_t      q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            run <= '0;
            q   <= '0;
        end else begin
            s1     <= din;
            s2     <= s1;
            q.rise <= 1'b0;
            q.fall <= 1'b0;
            if (s2 != q.level) begin
                if (run == CW'(FILT_CYC - 1)) begin
                    q.level <= s2;
                    q.rise  <= s2;
                    q.fall  <= ~s2;
                    run     <= '0;
                end else begin
                    run <= run + 1'b1;
                end
            end else begin
                run <= '0;
            end
        end
    end

    assign dout = q;
endmodule

// File: rtl/wd_timer_core.sv
module wd_timer_core
    import wd_pkg::*;
#(
    parameter wd_mode_e MODE        = MODE_SYM,
    parameter int       TIMEOUT_CYC = 40,
    parameter int       ACTIVE_CYC  = 100,
    parameter int       MIN_LOW_CYC = 12
) (
    input  logic     clk,
    input  logic     rst,
    input  wd_edge_t kick,
    input  logic     hold,
    output logic     alarm_n
);
    localparam int LOW_LEN = (MODE == MODE_FIXED) ? ACTIVE_CYC : TIMEOUT_CYC;
    localparam int CW      = wd_cw(wd_max(TIMEOUT_CYC, LOW_LEN));

    wd_state_e     st;
    logic [CW-1:0] cnt;
    logic          pend;
    logic          kick_hit;
    logic          early;
    logic          min_met;

    generate
        if (MODE == MODE_FIXED) begin : g_fixed
            assign kick_hit = kick.rise | kick.fall;
            assign early    = hold;
        end else begin : g_sym
            assign kick_hit = kick.rise;
            assign early    = hold | kick.rise;
        end
    endgenerate

    assign min_met = (cnt >= CW'(MIN_LOW_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_ARMED;
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            case (st)
                ST_ARMED: begin
                    pend <= 1'b0;
                    if (hold || kick_hit) begin
                        cnt <= '0;
                    end else if (cnt == CW'(TIMEOUT_CYC - 1)) begin
                        st  <= ST_ALARM;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if ((cnt == CW'(LOW_LEN - 1)) || (min_met && (pend || early))) begin
                        st   <= ST_ARMED;
                        cnt  <= '0;
                        pend <= 1'b0;
                    end else begin
                        cnt  <= cnt + 1'b1;
                        pend <= pend | early;
                    end
                end
            endcase
        end
    end

    assign alarm_n = (st == ST_ARMED);
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wd_pkg::*;
#(
    parameter wd_mode_e MODE        = MODE_SYM,
    parameter int       TIMEOUT_CYC = 40,
    parameter int       ACTIVE_CYC  = 100,
    parameter int       MIN_LOW_CYC = 12,
    parameter int       FILT_CYC    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_i,
    input  logic hold_i,
    output logic alarm_n_o
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    wd_edge_t        flt [N_IN];
    wd_edge_t        kick_e;
    wd_edge_t        hold_e;

    assign raw_in = {hold_i, kick_i};

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_in
            wd_sync_filter #(.FILT_CYC(FILT_CYC)) u_filt (
                .clk  (clk),
                .rst  (rst),
                .din  (raw_in[i]),
                .dout (flt[i])
            );
        end
    endgenerate

    assign kick_e = flt[0];
    assign hold_e = flt[1];

    wd_timer_core #(
        .MODE        (MODE),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .ACTIVE_CYC  (ACTIVE_CYC),
        .MIN_LOW_CYC (MIN_LOW_CYC)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .kick    (kick_e),
        .hold    (hold_e.level),
        .alarm_n (alarm_n_o)
    );
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk
    import wd_pkg::*;
#(
    parameter wd_mode_e MODE        = MODE_SYM,
    parameter int       TIMEOUT_CYC = 40,
    parameter int       ACTIVE_CYC  = 100,
    parameter int       MIN_LOW_CYC = 12
) (
    input logic     clk,
    input logic     rst,
    input logic     alarm_n,
    input wd_edge_t kick_e,
    input wd_edge_t hold_e
);
    localparam int LOW_LEN = (MODE == MODE_FIXED) ? ACTIVE_CYC : TIMEOUT_CYC;
    localparam bit FIXED   = (MODE == MODE_FIXED);

    int   low_len;
    int   high_len;
    logic early_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_len    <= 0;
            high_len   <= 0;
            early_seen <= 1'b0;
        end else if (alarm_n) begin
            low_len    <= 0;
            early_seen <= 1'b0;
            if (hold_e.level || kick_e.rise || (FIXED && kick_e.fall))
                high_len <= 0;
            else
                high_len <= high_len + 1;
        end else begin
            low_len  <= low_len + 1;
            high_len <= 0;
            if (hold_e.level || (!FIXED && kick_e.rise))
                early_seen <= 1'b1;
        end
    end

    assert_high_ceiling_R1: assert property (@(posedge clk) disable iff (rst)
        alarm_n |-> (high_len < TIMEOUT_CYC));

    assert_low_ceiling_R3: assert property (@(posedge clk) disable iff (rst)
        !alarm_n |-> (low_len < LOW_LEN));

    assert_full_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(alarm_n) && !early_seen) |-> (low_len == LOW_LEN));

    assert_low_floor_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_n) |-> (low_len >= MIN_LOW_CYC));

    assert_hold_keeps_high_R7: assert property (@(posedge clk) disable iff (rst)
        (alarm_n && (hold_e.level || hold_e.rise || hold_e.fall)) |=> alarm_n);
endmodule

bind wdog_supervisor wdog_supervisor_chk #(
    .MODE        (MODE),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .ACTIVE_CYC  (ACTIVE_CYC),
    .MIN_LOW_CYC (MIN_LOW_CYC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .alarm_n (alarm_n_o),
    .kick_e  (kick_e),
    .hold_e  (hold_e)
);

// File: tb/wdog_supervisor_tb.sv
module wdog_supervisor_tb;
    import wd_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic kick_s = 1'b0, hold_s = 1'b0;
    logic kick_f = 1'b0, hold_f = 1'b0;
    logic alarm_s, alarm_f;
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   done = 1'b0;

    typedef struct {
        int    at;
        bit    fixed;
        bit    exp;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;

    wdog_supervisor #(.MODE(MODE_SYM), .TIMEOUT_CYC(40), .ACTIVE_CYC(100),
                      .MIN_LOW_CYC(12), .FILT_CYC(4)) u_dut (
        .clk(clk), .rst(rst), .kick_i(kick_s), .hold_i(hold_s), .alarm_n_o(alarm_s));

    wdog_supervisor #(.MODE(MODE_FIXED), .TIMEOUT_CYC(40), .ACTIVE_CYC(100),
                      .MIN_LOW_CYC(12), .FILT_CYC(4)) u_dut_fp (
        .clk(clk), .rst(rst), .kick_i(kick_f), .hold_i(hold_f), .alarm_n_o(alarm_f));

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic push_exp(input int at, input bit fx, input bit v, input string tag);
        exp_t e;
        e.at = at; e.fixed = fx; e.exp = v; e.tag = tag;
        sbq.push_back(e);
    endtask

    // monitor: compares the scoreboard items due in this cycle
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = sbq.size() - 1; i >= 0; i--) begin
                if (sbq[i].at == cyc) begin
                    logic act;
                    act = sbq[i].fixed ? alarm_f : alarm_s;
                    n_checks++;
                    if (act !== sbq[i].exp) begin
                        n_fails++;
                        $display("FAIL %s cycle %0d mode %s: alarm_n actual %b expected %b",
                                 sbq[i].tag, cyc, sbq[i].fixed ? "fixed" : "sym", act, sbq[i].exp);
                    end
                    sbq.delete(i);
                end
            end
        end
    end

    task automatic at_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset();
        kick_s = 1'b0; hold_s = 1'b0; kick_f = 1'b0; hold_f = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        n_checks++;
        if (alarm_s !== 1'b1 || alarm_f !== 1'b1) begin
            n_fails++;
            $display("FAIL R10 during reset: alarm_n actual %b/%b expected 1/1", alarm_s, alarm_f);
        end
        rst = 1'b0;
    endtask

    task automatic finish_phase(input int c);
        at_cyc(c);
        @(negedge clk);
        if (sbq.size() != 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 scoreboard: actual %0d items left expected 0", sbq.size());
            sbq.delete();
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        // symmetric mode scenario
        do_reset();
        push_exp(1, 0, 1, "R10");   push_exp(39, 0, 1, "R1");  push_exp(40, 0, 0, "R1");
        push_exp(79, 0, 0, "R3");   push_exp(80, 0, 1, "R3");  push_exp(119, 0, 1, "R6");
        push_exp(120, 0, 0, "R3");  push_exp(131, 0, 0, "R5"); push_exp(132, 0, 1, "R5");
        push_exp(171, 0, 1, "R2");  push_exp(172, 0, 0, "R2"); push_exp(196, 0, 0, "R5");
        push_exp(197, 0, 1, "R5");  push_exp(240, 0, 1, "R2"); push_exp(266, 0, 1, "R1");
        push_exp(267, 0, 0, "R1");  push_exp(281, 0, 0, "R8"); push_exp(282, 0, 1, "R8");
        push_exp(445, 0, 1, "R7");  push_exp(446, 0, 0, "R7"); push_exp(457, 0, 0, "R8");
        push_exp(458, 0, 1, "R8");  push_exp(546, 0, 0, "R7"); push_exp(586, 0, 1, "R3");
        push_exp(625, 0, 1, "R9");  push_exp(626, 0, 0, "R9"); push_exp(710, 0, 1, "R9");
        push_exp(726, 0, 1, "R9");  push_exp(727, 0, 0, "R9");
        at_cyc(121); kick_s = 1'b1;   // early kick while low: held to min width
        at_cyc(140); kick_s = 1'b0;   // falling edge ignored
        at_cyc(190); kick_s = 1'b1;   // late kick while low: releases
        at_cyc(200); kick_s = 1'b0;
        at_cyc(220); kick_s = 1'b1;   // clears window
        at_cyc(275); hold_s = 1'b1;
        at_cyc(400); hold_s = 1'b0;
        at_cyc(447); hold_s = 1'b1;   // hold early in low pulse
        at_cyc(500); hold_s = 1'b0;
        at_cyc(550); kick_s = 1'b0;
        at_cyc(600); kick_s = 1'b1;   // 3-cycle glitch
        at_cyc(603); kick_s = 1'b0;
        at_cyc(680); kick_s = 1'b1;   // 4-cycle pulse accepted
        at_cyc(684); kick_s = 1'b0;
        finish_phase(740);

        // fixed-pulse mode scenario
        do_reset();
        push_exp(1, 1, 1, "R10");   push_exp(39, 1, 1, "R1");  push_exp(40, 1, 0, "R1");
        push_exp(139, 1, 0, "R4");  push_exp(140, 1, 1, "R4"); push_exp(185, 1, 1, "R2");
        push_exp(196, 1, 1, "R2");  push_exp(197, 1, 0, "R2"); push_exp(296, 1, 0, "R4");
        push_exp(297, 1, 1, "R4");  push_exp(366, 1, 1, "R6"); push_exp(367, 1, 0, "R2");
        push_exp(378, 1, 0, "R8");  push_exp(379, 1, 1, "R8"); push_exp(445, 1, 1, "R7");
        push_exp(446, 1, 0, "R7");
        at_cyc(50);  kick_f = 1'b1;   // kick while low: ignored
        at_cyc(150); kick_f = 1'b0;   // falling edge clears
        at_cyc(300); kick_f = 1'b1;
        at_cyc(320); kick_f = 1'b0;
        at_cyc(370); hold_f = 1'b1;
        at_cyc(400); hold_f = 1'b0;
        finish_phase(450);

        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        @(negedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R1 watchdog: actual run still active expected finished");
        summary();
    end
endmodule